// File: doc/BRIEF.md
# Single-Segment Memory DMA Engine

This block moves one contiguous buffer between system memory and a card data FIFO. Software programs a transfer mode, a 64-bit start address, and a byte length, then sets a start bit that clears itself. The engine then moves the buffer one beat at a time. In the memory-to-FIFO direction it issues a read request for each beat and pushes the returned word onto an outgoing ready/valid stream. In the FIFO-to-memory direction it takes a word from an incoming ready/valid stream and issues a write request carrying that word.

When the last beat finishes, a data-end status bit is set and an interrupt line rises. Each direction has its own channel-reset bit. Clearing that bit aborts any transfer running in that direction and holds the channel idle. Setting the bit again releases the channel. A build parameter can remove the FIFO-to-memory direction entirely.

Top module: `sdma_engine`

## Requirements
- R1: After reset the following hold:
  - the mode, address-low, address-high, length and status registers read 0;
  - the channel-reset register at 0x418 reads 0x300;
  - the control register reads 0;
  - no memory request or stream handshake is active, and `irq` is low.
- R2: The mode register at 0x410 has three fields:
  - bits 17:16 select the direction: 0 moves memory to the FIFO, 1 moves the FIFO to memory, and 2 or 3 make a start request be ignored;
  - bits 5:4 hold the width code w, giving a beat of 2^w bytes, driven on `mem_size`;
  - bit 0 set makes the address increment per beat.
- R3: Writing 1 to bit 0 of the control register at 0x414 starts a transfer from the address {0x444, 0x440} (high word, low word). The control register always reads back 0.
- R4: The beat count is the length register at 0x448 shifted right by w. With increment set, each beat's address is the previous one plus 2^w. With increment clear, every beat uses the start address. A start that would give zero beats is ignored.
- R5: In the memory-to-FIFO direction, each beat issues one read request. The returned word is held on `tx_data` with `tx_valid` until `tx_ready` is high.
- R6: In the FIFO-to-memory direction, each word accepted from the `rx_*` stream is written to memory by one write request carrying that word.
- R7: The status register at 0x41C has two bits:
  - bit 0 is data-end, set when the last beat completes and mirrored on `irq`; writing 1 to it clears it, and writing 0 leaves it unchanged;
  - bit 1 reads 1 while a transfer runs.
  When completion and a clear fall in the same cycle, data-end stays set.
- R8: A start written while a transfer runs is ignored. The running transfer keeps its address, length and mode, even if the registers are rewritten.
- R9: A start with width code 3 and a start address that is not a multiple of 8 is ignored.
- R10: The channel-reset register at 0x418 has one bit per direction: bit 8 for memory-to-FIFO and bit 9 for FIFO-to-memory.
  - Writing a bit to 0 aborts the running transfer in that direction. Requests and stream handshakes drop in the cycle after the write, and data-end is not set.
  - While a bit is 0, a start in that direction is ignored.
  - Writing the bit back to 1 releases the channel.
- R11: With parameter `RX_EN` = 0, a start in the FIFO-to-memory direction is ignored.
- R12: While `mem_req` waits for `mem_gnt`, `mem_addr` is held stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Request byte address |
| mem_size | output | 2 | Beat width code (2^w bytes) |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| tx_valid | output | 1 | Outgoing stream word valid |
| tx_data | output | DATA_W | Outgoing stream word |
| tx_ready | input | 1 | FIFO accepts outgoing word |
| rx_valid | input | 1 | Incoming stream word valid |
| rx_data | input | DATA_W | Incoming stream word |
| rx_ready | output | 1 | Engine accepts incoming word |
| irq | output | 1 | Data-end interrupt |

## Verification
Two events can fall in the same cycle: the completion of the final beat, which sets data-end, and a software write that clears data-end.

The bench provokes this by stalling the outgoing stream on the last beat. It then releases `tx_ready` in the very cycle the status clear-write is sampled, and requires that data-end still reads 1 afterwards.

A second overlap is a start written while a transfer is stalled waiting for a grant. That start is judged by the request addresses and the beat count that follow it.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_MODE = 12'h410;
  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h414;
  localparam logic [REG_AW-1:0] OFS_CRST = 12'h418;
  localparam logic [REG_AW-1:0] OFS_STAT = 12'h41C;
  localparam logic [REG_AW-1:0] OFS_ADRL = 12'h440;
  localparam logic [REG_AW-1:0] OFS_ADRH = 12'h444;
  localparam logic [REG_AW-1:0] OFS_LEN  = 12'h448;

  localparam int NCH      = 2;
  localparam int CH_TX    = 0;
  localparam int CH_RX    = 1;
  localparam int CRST_LSB = 8;

  typedef struct packed {
    logic [1:0] dir;
    logic [1:0] width;
    logic       inc;
  } xfer_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_TX_PUSH = 3'd3,
    ST_RX_WAIT = 3'd4,
    ST_WR_REQ  = 3'd5
  } eng_state_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int MEM_AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              xfer_done,
  input  logic              eng_busy,
  output xfer_mode_t        mode,
  output logic [MEM_AW-1:0] base_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic [NCH-1:0]    chan_run,
  output logic              start_req,
  output logic              dataend
);
  localparam int HI_W = MEM_AW - REG_DW;

  logic hit_mode, hit_ctrl, hit_crst, hit_stat, hit_adrl, hit_adrh, hit_len;
  xfer_mode_t        mode_q, mode_d;
  logic [REG_DW-1:0] adrl_q, adrl_d;
  logic [HI_W-1:0]   adrh_q, adrh_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              dend_q, dend_d, dend_en;

  assign hit_mode = wr_en && (addr == OFS_MODE);
  assign hit_ctrl = wr_en && (addr == OFS_CTRL);
  assign hit_crst = wr_en && (addr == OFS_CRST);
  assign hit_stat = wr_en && (addr == OFS_STAT);
  assign hit_adrl = wr_en && (addr == OFS_ADRL);
  assign hit_adrh = wr_en && (addr == OFS_ADRH);
  assign hit_len  = wr_en && (addr == OFS_LEN);

  assign start_req = hit_ctrl && wdata[0];

  always_comb begin
    mode_d  = '{dir: wdata[17:16], width: wdata[5:4], inc: wdata[0]};
    adrl_d  = wdata;
    adrh_d  = wdata[HI_W-1:0];
    len_d   = wdata[LEN_W-1:0];
    dend_en = xfer_done || (hit_stat && wdata[0]);
    dend_d  = xfer_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      adrl_q <= '0;
      adrh_q <= '0;
      len_q  <= '0;
      dend_q <= 1'b0;
    end else begin
      if (hit_mode) mode_q <= mode_d;
      if (hit_adrl) adrl_q <= adrl_d;
      if (hit_adrh) adrh_q <= adrh_d;
      if (hit_len)  len_q  <= len_d;
      if (dend_en)  dend_q <= dend_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic run_q, run_d;
    assign run_d = wdata[CRST_LSB + ch];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= 1'b1;
      else if (hit_crst) run_q <= run_d;
    end
    assign chan_run[ch] = run_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MODE: begin
        rdata[17:16] = mode_q.dir;
        rdata[5:4]   = mode_q.width;
        rdata[0]     = mode_q.inc;
      end
      OFS_CRST: rdata[CRST_LSB +: NCH] = chan_run;
      OFS_STAT: rdata[1:0] = {eng_busy, dend_q};
      OFS_ADRL: rdata = adrl_q;
      OFS_ADRH: rdata[HI_W-1:0] = adrh_q;
      OFS_LEN:  rdata[LEN_W-1:0] = len_q;
      default:  rdata = '0;
    endcase
  end

  assign mode      = mode_q;
  assign base_addr = {adrh_q, adrl_q};
  assign xfer_len  = len_q;
  assign dataend   = dend_q;
endmodule

// File: rtl/sdma_core.sv
module sdma_core
  import sdma_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MEM_AW = 64,
  parameter int LEN_W  = 16,
  parameter bit RX_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  xfer_mode_t        mode,
  input  logic [MEM_AW-1:0] base_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [NCH-1:0]    chan_run,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready
);
  eng_state_t        st_q, st_d;
  logic              rx_q, rx_d, inc_q, inc_d;
  logic [1:0]        wid_q, wid_d;
  logic [MEM_AW-1:0] cur_q, cur_d, step;
  logic [LEN_W-1:0]  left_q, left_d, beats_new;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic dir_rx, dir_ok, chan_ok, aligned, accept, live;
  logic beat_done, last_beat, buf_en, ctx_en;

  assign dir_rx    = (mode.dir == 2'd1);
  assign dir_ok    = (mode.dir == 2'd0) || (dir_rx && RX_EN);
  assign chan_ok   = dir_rx ? chan_run[CH_RX] : chan_run[CH_TX];
  assign beats_new = xfer_len >> mode.width;
  assign aligned   = !((mode.width == 2'd3) && (base_addr[2:0] != 3'b000));
  assign accept    = start_req && (st_q == ST_IDLE) && dir_ok && chan_ok
                     && (beats_new != '0) && aligned;
  assign live      = rx_q ? chan_run[CH_RX] : chan_run[CH_TX];
  assign step      = inc_q ? (MEM_AW'(1) << wid_q) : '0;
  assign last_beat = (left_q == LEN_W'(1));
  assign beat_done = live && (((st_q == ST_TX_PUSH) && tx_ready)
                           || ((st_q == ST_WR_REQ) && mem_gnt));
  assign buf_en    = ((st_q == ST_RD_WAIT) && mem_rvalid)
                  || ((st_q == ST_RX_WAIT) && rx_valid);
  assign ctx_en    = accept || beat_done;

  always_comb begin
    st_d   = st_q;
    rx_d   = rx_q;
    wid_d  = wid_q;
    inc_d  = inc_q;
    cur_d  = cur_q + step;
    left_d = left_q - LEN_W'(1);
    buf_d  = (st_q == ST_RX_WAIT) ? rx_data : mem_rdata;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = dir_rx ? ST_RX_WAIT : ST_RD_REQ;
        rx_d   = dir_rx;
        wid_d  = mode.width;
        inc_d  = mode.inc;
        cur_d  = base_addr;
        left_d = beats_new;
      end
      ST_RD_REQ:  if (mem_gnt)    st_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid) st_d = ST_TX_PUSH;
      ST_TX_PUSH: if (tx_ready)   st_d = last_beat ? ST_IDLE : ST_RD_REQ;
      ST_RX_WAIT: if (rx_valid)   st_d = ST_WR_REQ;
      ST_WR_REQ:  if (mem_gnt)    st_d = last_beat ? ST_IDLE : ST_RX_WAIT;
      default:                    st_d = ST_IDLE;
    endcase
    if ((st_q != ST_IDLE) && !live) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rx_q   <= 1'b0;
      wid_q  <= '0;
      inc_q  <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
      buf_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        rx_q  <= rx_d;
        wid_q <= wid_d;
        inc_q <= inc_d;
      end
      if (ctx_en) begin
        cur_q  <= cur_d;
        left_q <= left_d;
      end
      if (buf_en) buf_q <= buf_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = beat_done && last_beat;
  assign mem_req   = live && ((st_q == ST_RD_REQ) || (st_q == ST_WR_REQ));
  assign mem_we    = (st_q == ST_WR_REQ);
  assign mem_addr  = cur_q;
  assign mem_size  = wid_q;
  assign mem_wdata = buf_q;
  assign tx_valid  = live && (st_q == ST_TX_PUSH);
  assign tx_data   = buf_q;
  assign rx_ready  = live && (st_q == ST_RX_WAIT);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MEM_AW = 64,
  parameter int LEN_W  = 16,
  parameter bit RX_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  xfer_mode_t        mode;
  logic [MEM_AW-1:0] base_addr;
  logic [LEN_W-1:0]  xfer_len;
  logic [NCH-1:0]    chan_run;
  logic              start_req, eng_busy, xfer_done, dataend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdma_regs #(.LEN_W(LEN_W), .MEM_AW(MEM_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .xfer_done (xfer_done),
    .eng_busy  (eng_busy),
    .mode      (mode),
    .base_addr (base_addr),
    .xfer_len  (xfer_len),
    .chan_run  (chan_run),
    .start_req (start_req),
    .dataend   (dataend)
  );

  sdma_core #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .LEN_W(LEN_W), .RX_EN(RX_EN)) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_req  (start_req),
    .mode       (mode),
    .base_addr  (base_addr),
    .xfer_len   (xfer_len),
    .chan_run   (chan_run),
    .busy       (eng_busy),
    .done       (xfer_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready)
  );

  assign irq = dataend;
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk
  import sdma_pkg::*;
#(
  parameter int MEM_AW = 64,
  parameter bit RX_EN  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              tx_valid,
  input logic              rx_ready,
  input logic [NCH-1:0]    chan_run,
  input logic              busy,
  input logic              dataend
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[0];

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid, rx_ready})); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_req || tx_valid || rx_ready)); // R1

  AST_TX_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_run[CH_TX] |-> !(tx_valid || (mem_req && !mem_we))); // R10

  AST_RX_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_run[CH_RX] |-> !(rx_ready || (mem_req && mem_we))); // R10

  AST_DATAEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dataend && !clr_wr) |=> dataend); // R7

  AST_DATAEND_FROM_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataend) |-> $past(busy)); // R7

  AST_NO_RX_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !RX_EN |-> !(rx_ready || (mem_req && mem_we))); // R11

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (!mem_req || $stable(mem_addr))); // R12
endmodule

bind sdma_engine sdma_engine_chk #(.MEM_AW(MEM_AW), .RX_EN(RX_EN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .tx_valid  (tx_valid),
  .rx_ready  (rx_ready),
  .chan_run  (chan_run),
  .busy      (eng_busy),
  .dataend   (dataend)
);

// File: tb/sdma_engine_tb.sv
`timescale 1ns/1ps
module sdma_engine_tb;
  localparam logic [11:0] A_MODE = 12'h410, A_CTRL = 12'h414, A_CRST = 12'h418,
                          A_STAT = 12'h41C, A_ADRL = 12'h440, A_ADRH = 12'h444,
                          A_LEN  = 12'h448;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata, rdata2;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic tx_valid, tx_ready, rx_valid, rx_ready, irq;
  logic [63:0] tx_data, rx_data;
  logic mem_req2, mem_we2, tx_valid2, rx_ready2, irq2;
  logic [63:0] mem_addr2, mem_wdata2, tx_data2;
  logic [1:0] mem_size2;

  logic rx_en;
  logic rd_pend = 1'b0;
  logic [63:0] rd_addr = '0;
  int rq_n = 0, wr_n = 0, tx_n = 0, rx_idx = 0;
  logic [63:0] rq_log [0:127];
  logic [1:0]  rq_sz  [0:127];
  logic [63:0] wa_log [0:127];
  logic [63:0] wd_log [0:127];
  logic [1:0]  ws_log [0:127];
  logic [63:0] tx_log [0:127];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [63:0] pat(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A0F0F, ~a[31:0]};
  endfunction
  function automatic logic [63:0] rx_pat(input int i);
    return 64'hC0DE_0000_0000_0000 | 64'(i);
  endfunction

  sdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .irq(irq));

  sdma_engine #(.RX_EN(1'b0)) u_dut_norx (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata2), .mem_req(mem_req2),
    .mem_we(mem_we2), .mem_addr(mem_addr2), .mem_size(mem_size2),
    .mem_wdata(mem_wdata2), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid2), .tx_data(tx_data2),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready2), .irq(irq2));

  assign mem_rvalid = rd_pend;
  assign mem_rdata  = pat(rd_addr);
  assign rx_valid   = rx_en;
  assign rx_data    = rx_pat(rx_idx);

  always @(posedge clk) begin
    rd_pend <= mem_req && !mem_we && mem_gnt;
    if (mem_req && !mem_we && mem_gnt) begin
      rd_addr <= mem_addr;
      rq_log[rq_n & 127] <= mem_addr;
      rq_sz[rq_n & 127]  <= mem_size;
      rq_n <= rq_n + 1;
    end
    if (mem_req && mem_we && mem_gnt) begin
      wa_log[wr_n & 127] <= mem_addr;
      wd_log[wr_n & 127] <= mem_wdata;
      ws_log[wr_n & 127] <= mem_size;
      wr_n <= wr_n + 1;
    end
    if (tx_valid && tx_ready) begin
      tx_log[tx_n & 127] <= tx_data;
      tx_n <= tx_n + 1;
    end
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] m, input logic [63:0] a, input logic [31:0] l);
    wr(A_MODE, m);
    wr(A_ADRL, a[31:0]);
    wr(A_ADRH, a[63:32]);
    wr(A_LEN, l);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_MODE, v); chk("R1", "mode reg", 64'(v), 64'h0);
    rd(A_ADRL, v); chk("R1", "addr low", 64'(v), 64'h0);
    rd(A_ADRH, v); chk("R1", "addr high", 64'(v), 64'h0);
    rd(A_LEN, v);  chk("R1", "length", 64'(v), 64'h0);
    rd(A_STAT, v); chk("R1", "status", 64'(v), 64'h0);
    rd(A_CRST, v); chk("R1", "chan reset reg", 64'(v), 64'h300);
    rd(A_CTRL, v); chk("R1", "ctrl", 64'(v), 64'h0);
    chk("R1", "outputs quiet", {60'h0, mem_req, tx_valid, rx_ready, irq}, 64'h0);
  endtask

  task automatic t_tx_inc64();
    logic [31:0] v;
    int b = rq_n, t = tx_n;
    logic [63:0] base = 64'h0000_0001_0000_1000;
    setup(32'h31, base, 32);
    wr(A_CTRL, 1);
    rd(A_CTRL, v); chk("R3", "ctrl self-clears", 64'(v), 64'h0);
    wait_cyc(40);
    chk("R4", "beats 64b", 64'(rq_n - b), 64'd4);
    for (int k = 0; k < 4; k++) begin
      chk("R4", "inc addr 64b", rq_log[(b + k) & 127], base + 64'(8 * k));
      chk("R2", "mem_size 64b", 64'(rq_sz[(b + k) & 127]), 64'd3);
      chk("R5", "tx data", tx_log[(t + k) & 127], pat(base + 64'(8 * k)));
    end
    rd(A_STAT, v); chk("R7", "dataend set, idle", 64'(v), 64'h1);
    chk("R7", "irq high", 64'(irq), 64'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R7", "write 0 keeps dataend", 64'(v), 64'h1);
    wr(A_STAT, 1);
    rd(A_STAT, v); chk("R7", "W1C clears", 64'(v), 64'h0);
    chk("R7", "irq low", 64'(irq), 64'h0);
  endtask

  task automatic t_tx_fixed16();
    logic [31:0] v;
    int b = rq_n, t = tx_n;
    setup(32'h10, 64'h3002, 6);
    wr(A_CTRL, 1);
    wait_cyc(30);
    chk("R4", "beats 16b", 64'(rq_n - b), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R2", "fixed addr", rq_log[(b + k) & 127], 64'h3002);
      chk("R2", "mem_size 16b", 64'(rq_sz[(b + k) & 127]), 64'd1);
      chk("R5", "tx fixed data", tx_log[(t + k) & 127], pat(64'h3002));
    end
    rd(A_STAT, v); chk("R7", "dataend after fixed", 64'(v), 64'h1);
    wr(A_STAT, 1);
  endtask

  task automatic t_rx_inc32();
    logic [31:0] v;
    int w = wr_n, r0 = rx_idx;
    setup(32'h10021, 64'h2000, 12);
    wr(A_CTRL, 1);
    rx_en = 1'b1;
    wait_cyc(30);
    rx_en = 1'b0;
    chk("R6", "write count", 64'(wr_n - w), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R6", "write addr", wa_log[(w + k) & 127], 64'h2000 + 64'(4 * k));
      chk("R6", "write data", wd_log[(w + k) & 127], rx_pat(r0 + k));
      chk("R2", "write size", 64'(ws_log[(w + k) & 127]), 64'd2);
    end
    rd(A_STAT, v); chk("R7", "dataend after rx", 64'(v), 64'h1);
    wr(A_STAT, 1);
  endtask

  task automatic t_ignored_starts();
    logic [31:0] v;
    int b = rq_n;
    setup(32'h31, 64'h4004, 16);
    wr(A_CTRL, 1);
    wait_cyc(10);
    chk("R9", "misaligned 64b no request", 64'(rq_n - b), 64'd0);
    rd(A_STAT, v); chk("R9", "misaligned not busy", 64'(v), 64'h0);
    setup(32'h20031, 64'h5000, 16);
    wr(A_CTRL, 1);
    wait_cyc(10);
    chk("R2", "dir 2 ignored", {63'h0, rx_ready}, 64'h0);
    chk("R2", "dir 2 no request", 64'(rq_n - b), 64'd0);
    setup(32'h31, 64'h5000, 4);
    wr(A_CTRL, 1);
    wait_cyc(10);
    chk("R4", "zero beats ignored", 64'(rq_n - b), 64'd0);
    rd(A_STAT, v); chk("R4", "zero beats status", 64'(v), 64'h0);
  endtask

  task automatic t_busy_start();
    logic [31:0] v;
    int b = rq_n, t = tx_n;
    setup(32'h21, 64'h6000, 8);
    mem_gnt = 1'b0;
    wr(A_CTRL, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12", "addr held w/o grant", {mem_req, mem_addr[62:0]}, {1'b1, 63'h6000});
    end
    wr(A_ADRL, 32'h7000);
    wr(A_CTRL, 1);
    mem_gnt = 1'b1;
    wait_cyc(25);
    chk("R8", "beats after busy start", 64'(rq_n - b), 64'd2);
    chk("R8", "first addr", rq_log[b & 127], 64'h6000);
    chk("R8", "second addr", rq_log[(b + 1) & 127], 64'h6004);
    chk("R5", "busy-test data", tx_log[(t + 1) & 127], pat(64'h6004));
    rd(A_STAT, v); chk("R8", "single completion", 64'(v), 64'h1);
    wr(A_STAT, 1);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int b;
    tx_ready = 1'b0;
    setup(32'h31, 64'h8000, 32);
    wr(A_CTRL, 1);
    wait_cyc(8);
    chk("R5", "tx held without ready", {63'h0, tx_valid}, 64'h1);
    wr(A_CRST, 32'h200);
    chk("R10", "stop next cycle", {62'h0, tx_valid, mem_req}, 64'h0);
    wait_cyc(5);
    rd(A_STAT, v); chk("R10", "abort: idle, no dataend", 64'(v), 64'h0);
    rd(A_CRST, v); chk("R10", "reset reg held", 64'(v), 64'h200);
    tx_ready = 1'b1;
    b = rq_n;
    wr(A_CTRL, 1);
    wait_cyc(10);
    chk("R10", "start on held channel", 64'(rq_n - b), 64'd0);
    wr(A_CRST, 32'h300);
    wr(A_CTRL, 1);
    wait_cyc(40);
    chk("R10", "released channel runs", 64'(rq_n - b), 64'd4);
    rd(A_STAT, v); chk("R10", "dataend after release", 64'(v), 64'h1);
    wr(A_STAT, 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    tx_ready = 1'b0;
    setup(32'h31, 64'h100, 16);
    wr(A_CTRL, 1);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    while (!tx_valid) @(negedge clk);
    tx_ready = 1'b1;
    reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; tx_ready = 1'b1;
    rd(A_STAT, v); chk("R7", "set beats clear same cycle", 64'(v), 64'h1);
    chk("R7", "irq after collision", 64'(irq), 64'h1);
    wr(A_STAT, 1);
  endtask

  task automatic t_norx();
    logic [31:0] v;
    wr(A_CRST, 32'h000);
    wr(A_CRST, 32'h300);
    rx_en = 1'b0;
    setup(32'h10031, 64'h9000, 16);
    wr(A_CTRL, 1);
    wait_cyc(3);
    chk("R11", "full build accepts rx start", {63'h0, rx_ready}, 64'h1);
    chk("R11", "no-rx build ignores start", {63'h0, rx_ready2}, 64'h0);
    @(negedge clk); reg_addr = A_STAT; #1 v = rdata2;
    chk("R11", "no-rx build not busy", 64'(v), 64'h0);
    wr(A_CRST, 32'h100);
    wait_cyc(3);
    rd(A_STAT, v); chk("R10", "rx channel abort", 64'(v), 64'h0);
    wr(A_CRST, 32'h300);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_gnt = 1'b1; tx_ready = 1'b1; rx_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_tx_inc64();
    t_w1c();
    t_tx_fixed16();
    t_rx_inc32();
    t_ignored_starts();
    t_busy_start();
    t_abort();
    t_collide();
    t_norx();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule